// File: doc/BRIEF.md
# Compensated Seconds Real-Time Clock

This block keeps wall-clock time as a 32-bit count of seconds. A single-cycle enable, `ref_en`, marks each cycle of a 32.768 kHz reference. A prescaler counts those reference cycles and produces one seconds tick per period. The period is nominally 2^PRE_W cycles. On a programmable schedule the period is lengthened or shortened by a signed number of cycles, which trims out crystal frequency error. The range of correction covers roughly 0.12 ppm to 3906 ppm at the default widths.

The seconds count never wraps. When it is already at its maximum and a tick arrives, the count stays put and a time-invalid flag is raised, and counting stops until software writes a new time. The block also provides:
- a 32-bit alarm compare with a sticky flag,
- a one-cycle seconds interrupt,
- a 1 Hz square wave taken from the prescaler,
- a software reset held through a control bit,
- a lock bit that freezes the configuration until a reset.

Software reaches all of this through a flat register port: a write strobe, a 3-bit address, and a combinational read-data mux.

Top module: `crtc_top`

## Requirements
- R1: After rst_n the seconds count (address 0) reads 0, the prescaler (address 1), alarm (address 2), compensation (address 3) and control (address 4) read 0, and status (address 5) reads 1, i.e. bit 0 = time invalid set and bit 1 = alarm flag clear; sec_irq, alarm_irq and sq_out are low.
- R2: A tick arriving while the seconds count equals all ones leaves the count at all ones and sets the invalid flag (status bit 0); counting then stops.
- R3: With control bit 1 (enable) set and the invalid flag clear, the seconds count increments by one after every full prescaler period, which is 2^PRE_W reference cycles when no compensation applies; otherwise it holds.
- R4: When a tick brings the seconds count equal to the alarm register, status bit 1 sets and stays set until the alarm register is written; alarm_irq equals that flag ANDed with control bit 3.
- R5: When control bit 2 is set, sec_irq pulses high for exactly one cycle per tick, in the cycle the new seconds value is first visible.
- R6: Writes to the seconds count and the prescaler are ignored while the enable bit is set; a write to the seconds count while disabled loads it and clears the invalid flag.
- R7: The compensation register holds a signed cycle offset in bits 7:0 and an interval in bits 15:8. One second in every (interval+1) lasts 2^PRE_W minus that offset. A newly written pair is first used at the next compensated-second boundary.
- R8: While ref_en is low the prescaler value does not change.
- R9: While control bit 0 (soft reset) is set, every other register is held at its R1 value and writes to other registers are ignored; bit 0 itself remains writable.
- R10: Control bit 4 (lock) is sticky. Once set, writes to every register and to control bits 1 to 4 are ignored until rst_n or a soft reset.
- R11: sq_out is high exactly while the prescaler value is at least 2^(PRE_W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| ref_en | input | 1 | One pulse per reference (32.768 kHz) cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sec_irq | output | 1 | One-cycle seconds interrupt |
| alarm_irq | output | 1 | Alarm interrupt level |
| sq_out | output | 1 | 1 Hz square wave |

## Verification
The embedded properties watch the following on every cycle:
- after every tick, the prescaler returns to zero;
- the compensation interval counts down by one;
- the prescaler holds while the reference enable is low;
- the seconds count steps by exactly one, or pins at its maximum with the invalid flag;
- the alarm flag rises only on a match;
- the lock stays set;
- locked alarm writes leave the alarm untouched.

Properties cannot show some behaviours, and the bench scenarios cover them. These are the actual lengths of compensated seconds for positive and negative offsets and the one-boundary delay before a new setting applies. They also include the run up to the top of the count, the ignored writes while enabled, locked or under soft reset, and the full reset image of the register map.

// File: rtl/crtc_pkg.sv
`timescale 1ns/1ps
package crtc_pkg;
    typedef enum logic [2:0] {
        A_SECS  = 3'd0,
        A_PRE   = 3'd1,
        A_ALARM = 3'd2,
        A_COMP  = 3'd3,
        A_CTRL  = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    localparam int CB_SWR  = 0;
    localparam int CB_EN   = 1;
    localparam int CB_SIE  = 2;
    localparam int CB_AIE  = 3;
    localparam int CB_LOCK = 4;
endpackage

// File: rtl/crtc_prescaler.sv
`timescale 1ns/1ps
module crtc_prescaler #(
    parameter int PRE_W = 15,
    parameter int CMP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               ref_en,
    input  logic               wr_pre,
    input  logic [PRE_W:0]     wdata,
    input  logic [CMP_W-1:0]   comp_val,
    input  logic [CMP_W-1:0]   comp_ivl,
    output logic               tick,
    output logic [PRE_W:0]     pre_cnt,
    output logic               sq
);
    localparam int CNT_W = PRE_W + 1;
    localparam int LIM_W = PRE_W + 2;
    localparam int FULL  = 1 << PRE_W;
    localparam int HALF  = 1 << (PRE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] pre;
        logic [CMP_W-1:0] ivl;
        logic [CMP_W-1:0] val;
    } pst_t;

    pst_t st_q, st_d;
    logic signed [LIM_W-1:0] lim_m1;
    logic signed [LIM_W-1:0] pre_s;
    logic [CMP_W-1:0] ivl_cur;
    logic [CNT_W-1:0] pre_cur;

    always_comb begin
        lim_m1 = LIM_W'(FULL - 1);
        if (st_q.ivl == '0)
            lim_m1 = lim_m1 - LIM_W'($signed(st_q.val));
        pre_s = $signed({1'b0, st_q.pre});
        tick  = run && ref_en && (pre_s >= lim_m1);

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (wr_pre) begin
            st_d.pre = wdata;
        end else if (run && ref_en) begin
            if (tick) begin
                st_d.pre = '0;
                if (st_q.ivl == '0) begin
                    st_d.ivl = comp_ivl;
                    st_d.val = comp_val;
                end else begin
                    st_d.ivl = st_q.ivl - 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre_cnt = st_q.pre;
    assign sq      = (st_q.pre >= CNT_W'(HALF));
    assign ivl_cur = st_q.ivl;
    assign pre_cur = st_q.pre;

    // R3
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (pre_cur == '0));
    // R7
    ivl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && ivl_cur != '0) |=> (ivl_cur == $past(ivl_cur) - 1'b1));
    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en && !clr && !wr_pre) |=> $stable(pre_cur));
endmodule

// File: rtl/crtc_seconds.sv
`timescale 1ns/1ps
module crtc_seconds #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             wr_secs,
    input  logic             wr_alarm,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] secs,
    output logic [SEC_W-1:0] alarm,
    output logic             invalid,
    output logic             aflag
);
    typedef struct packed {
        logic [SEC_W-1:0] secs;
        logic [SEC_W-1:0] alarm;
        logic             inv;
        logic             aflag;
    } sst_t;

    sst_t st_q, st_d;
    logic [SEC_W-1:0] secs_inc;

    always_comb begin
        secs_inc = st_q.secs + 1'b1;
        st_d     = st_q;
        if (clr) begin
            st_d     = '0;
            st_d.inv = 1'b1;
        end else begin
            if (tick) begin
                if (st_q.secs == '1) begin
                    st_d.inv = 1'b1;
                end else begin
                    st_d.secs = secs_inc;
                    if (secs_inc == st_q.alarm) st_d.aflag = 1'b1;
                end
            end
            if (wr_secs) begin
                st_d.secs = wdata;
                st_d.inv  = 1'b0;
            end
            if (wr_alarm) begin
                st_d.alarm = wdata;
                st_d.aflag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.inv <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign secs    = st_q.secs;
    assign alarm   = st_q.alarm;
    assign invalid = st_q.inv;
    assign aflag   = st_q.aflag;

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !wr_secs && secs == '1) |=> (secs == '1 && invalid));
    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !wr_secs && secs != '1) |=> (secs == $past(secs) + 1'b1));
    // R4
    alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aflag) |-> (secs == alarm));
    // R9
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (secs == '0 && invalid && !aflag));
endmodule

// File: rtl/crtc_top.sv
`timescale 1ns/1ps
module crtc_top
    import crtc_pkg::*;
#(
    parameter int PRE_W = 15,
    parameter int SEC_W = 32,
    parameter int CMP_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        sec_irq,
    output logic        alarm_irq,
    output logic        sq_out
);
    localparam int CNT_W = PRE_W + 1;

    typedef struct packed {
        logic             swr;
        logic             en;
        logic             sie;
        logic             aie;
        logic             lock;
        logic [CMP_W-1:0] cval;
        logic [CMP_W-1:0] cint;
        logic             sirq;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             tick, run, wr_ok, wr_secs, wr_pre, wr_alarm;
    logic             invalid, aflag;
    logic [CNT_W-1:0] pre_cnt;
    logic [SEC_W-1:0] secs, alarm;

    assign wr_ok    = wr_en && !ctl_q.swr && !ctl_q.lock;
    assign wr_secs  = wr_ok && (addr == A_SECS) && !ctl_q.en;
    assign wr_pre   = wr_ok && (addr == A_PRE) && !ctl_q.en;
    assign wr_alarm = wr_ok && (addr == A_ALARM);
    assign run      = ctl_q.en && !invalid && !ctl_q.swr;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.sirq = tick && ctl_q.sie;
        if (ctl_q.swr) begin
            ctl_d.en   = 1'b0;
            ctl_d.sie  = 1'b0;
            ctl_d.aie  = 1'b0;
            ctl_d.lock = 1'b0;
            ctl_d.cval = '0;
            ctl_d.cint = '0;
        end
        if (wr_en && addr == A_CTRL) begin
            ctl_d.swr = wdata[CB_SWR];
            if (wr_ok) begin
                ctl_d.en   = wdata[CB_EN];
                ctl_d.sie  = wdata[CB_SIE];
                ctl_d.aie  = wdata[CB_AIE];
                ctl_d.lock = wdata[CB_LOCK];
            end
        end
        if (wr_ok && addr == A_COMP) begin
            ctl_d.cval = wdata[CMP_W-1:0];
            ctl_d.cint = wdata[2*CMP_W-1:CMP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    crtc_prescaler #(.PRE_W(PRE_W), .CMP_W(CMP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.swr),
        .run      (run),
        .ref_en   (ref_en),
        .wr_pre   (wr_pre),
        .wdata    (wdata[CNT_W-1:0]),
        .comp_val (ctl_q.cval),
        .comp_ivl (ctl_q.cint),
        .tick     (tick),
        .pre_cnt  (pre_cnt),
        .sq       (sq_out)
    );

    crtc_seconds #(.SEC_W(SEC_W)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.swr),
        .tick     (tick),
        .wr_secs  (wr_secs),
        .wr_alarm (wr_alarm),
        .wdata    (wdata[SEC_W-1:0]),
        .secs     (secs),
        .alarm    (alarm),
        .invalid  (invalid),
        .aflag    (aflag)
    );

    always_comb begin
        case (addr)
            A_SECS:  rdata = 32'(secs);
            A_PRE:   rdata = 32'(pre_cnt);
            A_ALARM: rdata = 32'(alarm);
            A_COMP:  rdata = 32'({ctl_q.cint, ctl_q.cval});
            A_CTRL:  rdata = {27'b0, ctl_q.lock, ctl_q.aie, ctl_q.sie, ctl_q.en, ctl_q.swr};
            A_STAT:  rdata = {30'b0, aflag, invalid};
            default: rdata = 32'b0;
        endcase
    end

    assign sec_irq   = ctl_q.sirq;
    assign alarm_irq = aflag && ctl_q.aie;

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.lock && !ctl_q.swr) |=> ctl_q.lock);
    // R10
    locked_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.lock && wr_en && addr == A_ALARM) |=> $stable(alarm));
    // R5
    sirq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |-> (pre_cnt == '0));
endmodule

// File: tb/crtc_top_tb.sv
`timescale 1ns/1ps
module crtc_top_tb;
    localparam int PW   = 8;
    localparam int FULL = 1 << PW;
    localparam int HALF = 1 << (PW - 1);

    logic        clk = 1'b0;
    logic        rst_n, ref_en, wr_en;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;
    logic        sec_irq, alarm_irq, sq_out;

    always #2 clk = ~clk;

    crtc_top #(.PRE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sec_irq(sec_irq), .alarm_irq(alarm_irq),
        .sq_out(sq_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // behavioural reference state
    longint m_secs, m_alarm;
    int     m_pre, m_ivl, m_val, m_cval, m_cint;
    bit     m_inv, m_aflag, m_swr, m_en, m_sie, m_aie, m_lock, m_sirq;

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return m_secs[31:0];
            3'd1: return 32'(m_pre);
            3'd2: return m_alarm[31:0];
            3'd3: return {16'b0, 8'(m_cint), 8'(m_cval)};
            3'd4: return {27'b0, m_lock, m_aie, m_sie, m_en, m_swr};
            3'd5: return {30'b0, m_aflag, m_inv};
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        int lim;
        bit run, tk, wok, nsirq;
        cyc++;
        if (!rst_n) begin
            m_secs = 0; m_alarm = 0; m_pre = 0; m_ivl = 0; m_val = 0;
            m_cval = 0; m_cint = 0; m_inv = 1; m_aflag = 0; m_swr = 0;
            m_en = 0; m_sie = 0; m_aie = 0; m_lock = 0; m_sirq = 0;
        end else begin
            lim   = (m_ivl == 0) ? FULL - m_val : FULL;
            run   = m_en && !m_inv && !m_swr;
            tk    = run && ref_en && (m_pre >= lim - 1);
            wok   = wr_en && !m_swr && !m_lock;
            nsirq = tk && m_sie;
            if (m_swr) begin
                m_pre = 0; m_ivl = 0; m_val = 0;
                m_secs = 0; m_alarm = 0; m_inv = 1; m_aflag = 0;
            end else begin
                if (wok && addr == 3'd1 && !m_en) m_pre = int'(wdata[PW:0]);
                else if (run && ref_en) begin
                    if (tk) begin
                        m_pre = 0;
                        if (m_ivl == 0) begin m_ivl = m_cint; m_val = m_cval; end
                        else m_ivl = m_ivl - 1;
                    end else m_pre = m_pre + 1;
                end
                if (tk) begin
                    if (m_secs == 64'hFFFF_FFFF) m_inv = 1;
                    else begin
                        m_secs = m_secs + 1;
                        if (m_secs == m_alarm) m_aflag = 1;
                    end
                end
                if (wok && addr == 3'd0 && !m_en) begin m_secs = wdata; m_inv = 0; end
                if (wok && addr == 3'd2) begin m_alarm = wdata; m_aflag = 0; end
            end
            if (m_swr) begin
                m_en = 0; m_sie = 0; m_aie = 0; m_lock = 0; m_cval = 0; m_cint = 0;
            end
            if (wr_en && addr == 3'd4) begin
                m_swr = wdata[0];
                if (wok) begin
                    m_en = wdata[1]; m_sie = wdata[2]; m_aie = wdata[3]; m_lock = wdata[4];
                end
            end
            if (wok && addr == 3'd3) begin
                m_cval = int'($signed(wdata[7:0]));
                m_cint = int'(wdata[15:8]);
            end
            m_sirq = nsirq;
        end
    end

    // per-cycle comparison of the output pins against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({31'b0, sq_out},    {31'b0, (m_pre >= HALF)},      "R11 sq_out");
            check({31'b0, sec_irq},   {31'b0, m_sirq},               "R5 sec_irq");
            check({31'b0, alarm_irq}, {31'b0, (m_aflag && m_aie)},   "R4 alarm_irq");
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v, exp, tag);
        check(v, mread(a), {tag, " model"});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int t);
        do @(negedge clk); while (!sec_irq);
        t = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t[0:5];
        logic [31:0] v1, v2;
        rst_n = 1'b0; ref_en = 1'b1; wr_en = 1'b0; addr = 3'd0; wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image
        rd_chk(3'd0, 32'd0, "R1 secs");
        rd_chk(3'd4, 32'd0, "R1 ctrl");
        rd_chk(3'd5, 32'd1, "R1 status");
        rd_chk(3'd3, 32'd0, "R1 comp");

        // R6 time write clears invalid
        wr(3'd0, 32'd100);
        rd_chk(3'd5, 32'd0, "R6 invalid cleared");
        wr(3'd1, 32'd0);

        // R3 counting, R5 interrupt on
        wr(3'd4, 32'h6);
        idle(3 * FULL + 10);
        rd_chk(3'd0, 32'd103, "R3 three seconds");

        // R6 ignored while enabled
        wr(3'd0, 32'd5);
        rd_chk(3'd0, 32'd103, "R6 secs write ignored");

        // R4 alarm
        wr(3'd2, 32'd105);
        wr(3'd4, 32'hE);
        idle(3 * FULL);
        check({31'b0, alarm_irq}, 32'd1, "R4 alarm_irq set");
        rd_chk(3'd5, 32'd2, "R4 alarm flag");
        wr(3'd2, 32'd0);
        rd_chk(3'd5, 32'd0, "R4 flag cleared by alarm write");

        // R7 positive offset, interval 1
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0000_0110);
        wr(3'd1, 32'd0);
        wr(3'd4, 32'h6);
        for (int i = 0; i < 5; i++) wait_irq(t[i]);
        check(32'(t[1] - t[0]), 32'(FULL),      "R7 plain second");
        check(32'(t[2] - t[1]), 32'(FULL - 16), "R7 shortened second");
        check(32'(t[3] - t[2]), 32'(FULL),      "R7 plain second again");
        check(32'(t[4] - t[3]), 32'(FULL - 16), "R7 shortened second again");

        // R7 negative offset every second
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0000_00E0);
        wr(3'd4, 32'h6);
        for (int i = 0; i < 5; i++) wait_irq(t[i]);
        check(32'(t[4] - t[3]), 32'(FULL + 32), "R7 lengthened second");

        // R8 reference enable low freezes prescaler
        @(negedge clk); ref_en = 1'b0;
        rd(3'd1, v1);
        idle(20);
        rd(3'd1, v2);
        check(v2, v1, "R8 prescaler frozen");
        check(v2, mread(3'd1), "R8 model");
        @(negedge clk); ref_en = 1'b1;

        // R2 no rollover
        wr(3'd4, 32'h0);
        wr(3'd0, 32'hFFFF_FFFE);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h6);
        idle(1500);
        rd_chk(3'd0, 32'hFFFF_FFFF, "R2 count pinned");
        rd_chk(3'd5, 32'd1, "R2 invalid set");

        // R6 invalid cleared by a time write when disabled
        wr(3'd4, 32'h0);
        wr(3'd0, 32'd7);
        rd_chk(3'd5, 32'd0, "R6 invalid cleared again");

        // R10 lock
        wr(3'd4, 32'h10);
        wr(3'd2, 32'h55);
        rd_chk(3'd2, 32'd0, "R10 alarm write ignored");
        wr(3'd3, 32'h0000_0203);
        rd_chk(3'd3, 32'd0, "R10 comp write ignored");
        wr(3'd4, 32'h2);
        rd_chk(3'd4, 32'h10, "R10 ctrl bits frozen");

        // R9 soft reset
        wr(3'd4, 32'h1);
        rd_chk(3'd4, 32'h1, "R9 ctrl under soft reset");
        rd_chk(3'd0, 32'd0, "R9 secs cleared");
        rd_chk(3'd5, 32'd1, "R9 status invalid");
        wr(3'd2, 32'd9);
        rd_chk(3'd2, 32'd0, "R9 alarm write ignored");
        wr(3'd4, 32'h0);
        wr(3'd2, 32'd9);
        rd_chk(3'd2, 32'd9, "R9 writes resume, lock released");
        rd_chk(3'd4, 32'd0, "R9 ctrl clear");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule